// File: doc/BRIEF.md
# Accumulate-and-Difference Sample Filter with Output Freeze

This block filters a stream of unsigned 8-bit samples, taking one sample on every rising clock edge. Each sample first goes through a threshold gate. A sample at or above the programmed threshold enters the filter loop as it is. A sample below the threshold is replaced by zero.

The gated sample goes into a recursive accumulator. The accumulator adds the sample to the stored previous filter result and gives a 9-bit sum. A difference stage then subtracts that same stored result from the sum, which gives the 8-bit filter output. Both stages read one shared past-result register, so the loop returns the gated sample. The accumulator sum is also visible at the ports.

A freeze control holds the visible 8-bit output at its last value. It does not stop the loop underneath. The shared past-result register keeps taking the unfrozen result, so the recursion continues as if no freeze had happened. A synchronous reset clears all state.

Top module: `intdiff_hold_filter`

## Requirements
- R1: When `rst_i` is high at a rising edge, `integ_o`, `filt_o` and the internal past result are all zero after that edge.
- R2: After a rising edge with `rst_i` low, `integ_o` equals the gated sample presented at that edge plus the unfrozen filter result of the previous edge (zero after reset).
- R3: After a rising edge with `rst_i` and `freeze_i` low, `filt_o` equals the `integ_o` of that edge minus the previous unfrozen result, truncated to 8 bits. This makes it equal to the gated sample.
- R4: After a rising edge with `freeze_i` high and `rst_i` low, `filt_o` keeps the value it had before that edge.
- R5: `freeze_i` has no effect on the loop. The past result taken at a frozen edge is the unfrozen result, so the next `integ_o` uses it (for example, 28 and then a frozen 30 followed by 28 gives 58, not 56).
- R6: The gated sample is `sample_i` when `sample_i >= thresh_i` (unsigned compare) and zero otherwise. A threshold of zero passes every sample.
- R7: `integ_o` is 9 bits unsigned and never wraps. The largest reachable value, 255 + 255 = 510, appears exactly.
- R8: Reset takes priority over freeze. An edge with both `rst_i` and `freeze_i` high clears `filt_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| freeze_i | input | 1 | Holds the visible filter output at its current value |
| thresh_i | input | 8 | Minimum sample value admitted to the loop |
| sample_i | input | 8 | Unsigned input sample |
| integ_o | output | 9 | Registered accumulator sum |
| filt_o | output | 8 | Registered filter output |

## Verification
Some properties are checked on every cycle. Reset clears both outputs. A frozen edge leaves `filt_o` unchanged. An unfrozen edge sets `filt_o` to the gated sample of the edge before. The accumulator never falls below the gated sample it just added, and it stays within 510.

Other behaviours only show up over a sequence of cycles, so the bench scenarios cover them. The first is the hidden recursion continuing through a freeze, which shows up in the `integ_o` value on the next edge. The bench also sweeps every sample value against several thresholds and drives reset together with freeze.

// File: rtl/idf_pkg.sv
package idf_pkg;
    localparam int unsigned DFLT_W = 8;

    // Width needed to hold the sum of two W-bit unsigned values
    function automatic int unsigned sum_width(input int unsigned w);
        return w + 1;
    endfunction
endpackage

// File: rtl/idf_gate.sv
module idf_gate #(
    parameter int unsigned W       = idf_pkg::DFLT_W,
    parameter bit          GATE_EN = 1'b1
) (
    input  logic [W-1:0] smp_i,
    input  logic [W-1:0] thr_i,
    output logic [W-1:0] gated_o
);
    logic admit;

    generate
        if (GATE_EN) begin : g_cmp
            always_comb admit = (smp_i >= thr_i);
        end else begin : g_bypass
            logic unused_thr;
            always_comb unused_thr = ^thr_i;
            always_comb admit = 1'b1;
        end
    endgenerate

    // 2:1 selector: admitted sample or zero
    always_comb gated_o = admit ? smp_i : '0;
endmodule

// File: rtl/idf_accum.sv
module idf_accum #(
    parameter int unsigned W  = idf_pkg::DFLT_W,
    localparam int unsigned IW = idf_pkg::sum_width(W)
) (
    input  logic [W-1:0]  x_i,
    input  logic [W-1:0]  prev_i,
    output logic [IW-1:0] sum_o
);
    always_comb sum_o = {1'b0, x_i} + {1'b0, prev_i};
endmodule

// File: rtl/idf_diff.sv
module idf_diff #(
    parameter int unsigned W  = idf_pkg::DFLT_W,
    localparam int unsigned IW = idf_pkg::sum_width(W)
) (
    input  logic [IW-1:0] sum_i,
    input  logic [W-1:0]  prev_i,
    output logic [W-1:0]  diff_o
);
    logic [IW-1:0] full;

    always_comb begin
        full   = sum_i - {1'b0, prev_i};
        diff_o = full[W-1:0];
    end
endmodule

// File: rtl/intdiff_hold_filter.sv
module intdiff_hold_filter #(
    parameter int unsigned W = idf_pkg::DFLT_W,
    localparam int unsigned IW = idf_pkg::sum_width(W)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          freeze_i,
    input  logic [W-1:0]  thresh_i,
    input  logic [W-1:0]  sample_i,
    output logic [IW-1:0] integ_o,
    output logic [W-1:0]  filt_o
);
    typedef struct packed {
        logic [IW-1:0] integ;
        logic [W-1:0]  filt;
        logic [W-1:0]  past;
    } state_t;

    state_t st_d, st_q;

    logic [W-1:0]  gate_smp;
    logic [IW-1:0] sum_c;
    logic [W-1:0]  diff_c;

    idf_gate #(.W(W), .GATE_EN(1'b1)) u_gate (
        .smp_i   (sample_i),
        .thr_i   (thresh_i),
        .gated_o (gate_smp)
    );

    idf_accum #(.W(W)) u_accum (
        .x_i    (gate_smp),
        .prev_i (st_q.past),
        .sum_o  (sum_c)
    );

    idf_diff #(.W(W)) u_diff (
        .sum_i  (sum_c),
        .prev_i (st_q.past),
        .diff_o (diff_c)
    );

    always_comb begin
        st_d = st_q;
        if (rst_i) begin
            st_d = '0;
        end else begin
            st_d.integ = sum_c;
            st_d.past  = diff_c;          // loop always sees the unfrozen result
            if (!freeze_i) begin
                st_d.filt = diff_c;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign integ_o = st_q.integ;
    assign filt_o  = st_q.filt;

    // R1 / R8: reset clears visible state, freeze or not
    p_reset_clears_r1: assert property (@(posedge clk_i)
        rst_i |=> (integ_o == '0 && filt_o == '0));

    // R4: frozen edge keeps the visible output
    p_freeze_keeps_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        freeze_i |=> (filt_o == $past(filt_o)));

    // R3: unfrozen edge outputs the gated sample
    p_out_tracks_gate_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        !freeze_i |=> (filt_o == $past(gate_smp)));

    // R2: accumulator never below the sample it added
    p_sum_covers_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> (integ_o >= {1'b0, $past(gate_smp)}));

    // R7: sum stays within twice the sample range
    p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> (integ_o <= IW'(2 * ((1 << W) - 1))));
endmodule

// File: tb/sim_intdiff_hold_filter.sv
`timescale 1ns/1ps
module sim_intdiff_hold_filter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frz = 1'b0;
    logic [7:0] thr = 8'd0;
    logic [7:0] smp = 8'd0;
    logic [8:0] integ;
    logic [7:0] filt;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // expected model
    int m_integ = 0;
    int m_filt  = 0;
    int m_past  = 0;

    always #10 clk = ~clk;

    intdiff_hold_filter u0 (
        .clk_i(clk), .rst_i(rst), .freeze_i(frz), .thresh_i(thr),
        .sample_i(smp), .integ_o(integ), .filt_o(filt)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // drive at negedge, model the edge, compare at next negedge
    task automatic step(input int x, input int t, input bit f, input bit r,
                        input string tag);
        int g;
        smp = x[7:0]; thr = t[7:0]; frz = f; rst = r;
        @(posedge clk);
        if (r) begin
            m_integ = 0; m_filt = 0; m_past = 0;
        end else begin
            g = (x >= t) ? x : 0;
            m_integ = g + m_past;
            m_past  = (m_integ - m_past) & 255;
            if (!f) m_filt = m_past;
        end
        @(negedge clk);
        check({tag, " integ"}, int'(integ), m_integ);
        check({tag, " filt"},  int'(filt),  m_filt);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        int seq[19] = '{0,60,46,38,29,28,30,28,30,36,51,53,62,65,69,72,79,82,79};
        int frzpat[19] = '{0,0,0,0,0,0,1,0,0,0,0,1,0,0,0,0,1,0,0};
        @(negedge clk);
        step(77, 0, 0, 1, "R1 reset");
        // worked sequence with freezes, threshold 0 (R6 passes all)
        for (int i = 1; i < 19; i++)
            step(seq[i], 0, frzpat[i][0], 0, frzpat[i] ? "R4 R5 freeze" : "R2 R3 seq");
        // explicit recursion through a freeze: 28, frozen 30, then 28 -> 58
        step(28, 0, 0, 0, "R3 pre");
        step(30, 0, 1, 0, "R4 frozen");
        step(28, 0, 0, 0, "R5 after freeze");
        // overflow corner
        step(255, 0, 0, 0, "R7 max a");
        step(255, 0, 0, 0, "R7 max 510");
        // reset wins over freeze
        step(9, 0, 1, 1, "R8 reset+freeze");
        step(5, 0, 0, 0, "R1 after reset");
        // exhaustive sweep across thresholds
        for (int ti = 0; ti < 4; ti++) begin
            int tv;
            tv = (ti == 0) ? 0 : (ti == 1) ? 100 : (ti == 2) ? 200 : 255;
            for (int x = 0; x < 256; x++)
                step(x, tv, (x % 7) == 3, 0, "R6 sweep");
        end
        step(50, 0, 0, 1, "R1 final reset");
        done = 1'b1;
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            report();
        end
    end
endmodule